// File: doc/BRIEF.md
# Triggered Delayed Pulse Generator

This block produces one timed pulse on a two-wire switch control (an enable line and an active-low select line) after a chosen trigger. A host steers it with short ASCII commands on a byte stream. Each command is a capital letter, optionally followed by decimal digits, and ends with a line feed. Delay and width are given in nanoseconds and stored as whole clock cycles.

Two trigger sources share one arm/disarm command set. The first is a rising edge on a reset-style input line. The second is the Nth edge, of either polarity, on a data input line. Once armed, the block waits for its trigger, counts the delay, then holds the select line low for the width. After that it disarms itself.

A calibration command measures the number of clock cycles between two successive data-line edges. A status command reports the configured values and the last measurement as fixed-width hexadecimal fields.

Top module: `trig_pulse_gen`

## Requirements
- R1: While reset is held, `sw_en` is 0. From the first clock after reset, `sw_en` is 1 and `sw_sel_n` is 1. Reset leaves delay = 1 cycle, width = 1 cycle, edge target = 24 and measurement = 0.
- R2: `D<n>` sets the delay and `W<n>` sets the width. Each is stored as ceil(n / CLK_PERIOD_NS) cycles, with a minimum of 1. `E<n>` sets the edge target, with a minimum of 1. With the default 4 ns period, D10 gives 3 cycles and W7 gives 2.
- R3: A command is one letter A–Z, then optional digits 0–9, then line feed (0x0A). Carriage return (0x0D) is ignored. Each accepted command is answered with the three bytes 'O', 'K', 0x0A. An unknown letter gets no reply.
- R4: After `R`, a rising edge on `line_rst` makes `sw_sel_n` fall on the (delay+3)-th rising clock edge after the input change. `sw_sel_n` then stays low for exactly width cycles, and `sw_en` stays 1 throughout.
- R5: After `B`, data-line edges of both polarities are counted from zero. The edge whose count reaches the target triggers, with the same delay+3 latency. Earlier edges produce no pulse.
- R6: After one pulse the block is disarmed. Further trigger edges produce no pulse until a new arm command is accepted.
- R7: `X` disarms the block, aborts a pending delay or pulse, and is acknowledged. No pulse follows the abort.
- R8: `R` or `B` received during a delay or pulse is ignored. It gets no reply, and the running pulse keeps its timing.
- R9: `T` arms a measurement. The first data-line edge afterwards starts it, and the next edge stores the number of clock cycles between the two edges.
- R10: `S` replies with four 8-digit uppercase hex fields: delay cycles, width cycles, edge target, and last measurement. The fields are separated by spaces (0x20) and the reply ends with 0x0A. No 'OK' is sent for `S`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | Command byte present this cycle |
| rx_data | input | 8 | Command byte |
| tx_valid | output | 1 | Reply byte present |
| tx_data | output | 8 | Reply byte |
| tx_ready | input | 1 | Reply byte consumed this cycle |
| line_rst | input | 1 | Asynchronous reset-style trigger line |
| line_dat | input | 1 | Asynchronous data line carrying edges |
| sw_en | output | 1 | Switch enable, 1 connects the path |
| sw_sel_n | output | 1 | Switch select, 0 during the pulse |

## Verification
A single data-line edge can feed two functions in the same cycle. It can advance the edge-trigger count and also start or stop a calibration measurement. The bench arms edge-trigger mode with a target of two and a measurement together, then applies two edges seven cycles apart. The second edge must both fire the pulse at the expected cycle and leave a status measurement of exactly 7, so the two paths are shown not to steal the edge from each other.

// File: rtl/tpg_pkg.sv
// Shared types, character codes and the nanosecond-to-cycle conversion.
// Assumes ASCII command bytes.
package tpg_pkg;
    typedef enum logic [2:0] {ST_IDLE, ST_WAIT_RST, ST_WAIT_EDGE, ST_DELAY, ST_PULSE} fire_st_t;
    typedef enum logic [1:0] {M_IDLE, M_ARMED, M_RUN} meas_st_t;
    typedef enum logic [1:0] {RP_NONE, RP_OK, RP_STATUS} reply_t;

    localparam logic [7:0] CH_LF = 8'h0A;
    localparam logic [7:0] CH_SP = 8'h20;
    localparam logic [7:0] OP_DELAY  = 8'h44; // D
    localparam logic [7:0] OP_WIDTH  = 8'h57; // W
    localparam logic [7:0] OP_EDGES  = 8'h45; // E
    localparam logic [7:0] OP_ARM_R  = 8'h52; // R
    localparam logic [7:0] OP_ARM_B  = 8'h42; // B
    localparam logic [7:0] OP_DISARM = 8'h58; // X
    localparam logic [7:0] OP_STATUS = 8'h53; // S
    localparam logic [7:0] OP_MEAS   = 8'h54; // T

    // Round a nanosecond count up to whole cycles, never below one.
    function automatic logic [31:0] ns_to_cyc(input logic [31:0] ns, input int unsigned period);
        logic [32:0] q;
        q = ({1'b0, ns} + 33'(period) - 33'd1) / 33'(period);
        return (q == '0) ? 32'd1 : q[31:0];
    endfunction
endpackage

// File: rtl/tpg_cmd_rx.sv
// Command byte parser: a letter opens a command, digits build its decimal
// value, line feed issues it as a one-cycle strobe. Other bytes are dropped.
// Assumes values fit in VAL_W bits (larger values wrap).
module tpg_cmd_rx #(
    parameter int VAL_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    output logic             cmd_valid,
    output logic [7:0]       cmd_op,
    output logic [VAL_W-1:0] cmd_val
);
    logic [7:0]       letter_q;
    logic [VAL_W-1:0] acc_q;
    logic             is_digit, is_letter;

    assign is_digit  = (rx_data >= 8'h30) && (rx_data <= 8'h39);
    assign is_letter = (rx_data >= 8'h41) && (rx_data <= 8'h5A);

    // Collect letter and digits; emit command on line feed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            letter_q  <= '0;
            acc_q     <= '0;
            cmd_valid <= 1'b0;
            cmd_op    <= '0;
            cmd_val   <= '0;
        end else begin
            cmd_valid <= 1'b0;
            if (rx_valid) begin
                if (rx_data == tpg_pkg::CH_LF) begin
                    cmd_valid <= (letter_q != '0);
                    cmd_op    <= letter_q;
                    cmd_val   <= acc_q;
                    letter_q  <= '0;
                    acc_q     <= '0;
                end else if (is_digit) begin
                    acc_q <= acc_q * VAL_W'(10) + VAL_W'(rx_data - 8'h30);
                end else if (is_letter) begin
                    letter_q <= rx_data;
                    acc_q    <= '0;
                end
            end
        end
    end
endmodule

// File: rtl/tpg_in_sync.sv
// Two-flop synchroniser plus edge detector for each of N asynchronous lines.
// An edge is reported two clocks after it is first sampled.
module tpg_in_sync #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] rise,
    output logic [N-1:0] toggle
);
    for (genvar i = 0; i < N; i++) begin : g_line
        logic [2:0] sh;
        // Shift: two sync stages, then the previous synchronised value.
        always_ff @(posedge clk) begin
            if (!rst_n) sh <= '0;
            else        sh <= {sh[1:0], din[i]};
        end
        assign rise[i]   = sh[1] & ~sh[2];
        assign toggle[i] = sh[1] ^ sh[2];
    end
endmodule

// File: rtl/tpg_fire_ctrl.sv
// Configuration registers, arm/trigger/delay/pulse sequencer and the
// edge-interval measurement. Requests a reply for each accepted command.
// Assumes the trigger inputs are already synchronised.
module tpg_fire_ctrl
    import tpg_pkg::*;
#(
    parameter int CNT_W         = 32,
    parameter int CLK_PERIOD_NS = 4,
    parameter int EDGE_DEFAULT  = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [7:0]       cmd_op,
    input  logic [CNT_W-1:0] cmd_val,
    input  logic             rst_rise,
    input  logic             dat_edge,
    output logic             pulse_on,
    output reply_t           reply_req,
    output logic [CNT_W-1:0] delay_cyc,
    output logic [CNT_W-1:0] width_cyc,
    output logic [CNT_W-1:0] edge_tgt,
    output logic [CNT_W-1:0] meas_cyc
);
    fire_st_t         state;
    meas_st_t         m_st;
    logic [CNT_W-1:0] cnt, ecnt, mcnt;
    logic             busy, is_arm;

    assign busy     = (state == ST_DELAY) || (state == ST_PULSE);
    assign pulse_on = (state == ST_PULSE);
    assign is_arm   = cmd_valid && ((cmd_op == OP_ARM_R) || (cmd_op == OP_ARM_B));

    // Sequencer and configuration: trigger wait, delay, pulse, commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            ecnt      <= '0;
            delay_cyc <= CNT_W'(1);
            width_cyc <= CNT_W'(1);
            edge_tgt  <= CNT_W'(EDGE_DEFAULT);
            reply_req <= RP_NONE;
        end else begin
            reply_req <= RP_NONE;
            case (state)
                ST_WAIT_RST: if (rst_rise) begin
                    state <= ST_DELAY;
                    cnt   <= CNT_W'(1);
                end
                ST_WAIT_EDGE: if (dat_edge) begin
                    if (ecnt + CNT_W'(1) >= edge_tgt) begin
                        state <= ST_DELAY;
                        cnt   <= CNT_W'(1);
                    end else begin
                        ecnt <= ecnt + CNT_W'(1);
                    end
                end
                ST_DELAY: if (cnt >= delay_cyc) begin
                    state <= ST_PULSE;
                    cnt   <= CNT_W'(1);
                end else begin
                    cnt <= cnt + CNT_W'(1);
                end
                ST_PULSE: if (cnt >= width_cyc) state <= ST_IDLE;
                          else cnt <= cnt + CNT_W'(1);
                default: ;
            endcase
            if (cmd_valid) begin
                case (cmd_op)
                    OP_DELAY: begin
                        delay_cyc <= CNT_W'(ns_to_cyc(32'(cmd_val), CLK_PERIOD_NS));
                        reply_req <= RP_OK;
                    end
                    OP_WIDTH: begin
                        width_cyc <= CNT_W'(ns_to_cyc(32'(cmd_val), CLK_PERIOD_NS));
                        reply_req <= RP_OK;
                    end
                    OP_EDGES: begin
                        edge_tgt  <= (cmd_val == '0) ? CNT_W'(1) : cmd_val;
                        reply_req <= RP_OK;
                    end
                    OP_ARM_R: if (!busy) begin
                        state     <= ST_WAIT_RST;
                        reply_req <= RP_OK;
                    end
                    OP_ARM_B: if (!busy) begin
                        state     <= ST_WAIT_EDGE;
                        ecnt      <= '0;
                        reply_req <= RP_OK;
                    end
                    OP_DISARM: begin
                        state     <= ST_IDLE;
                        reply_req <= RP_OK;
                    end
                    OP_STATUS: reply_req <= RP_STATUS;
                    OP_MEAS:   reply_req <= RP_OK;
                    default: ;
                endcase
            end
        end
    end

    // Calibration: cycles between the first two data edges after T.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_st     <= M_IDLE;
            mcnt     <= '0;
            meas_cyc <= '0;
        end else if (cmd_valid && cmd_op == OP_MEAS) begin
            m_st <= M_ARMED;
        end else begin
            case (m_st)
                M_ARMED: if (dat_edge) begin
                    m_st <= M_RUN;
                    mcnt <= CNT_W'(1);
                end
                M_RUN: if (dat_edge) begin
                    meas_cyc <= mcnt;
                    m_st     <= M_IDLE;
                end else begin
                    mcnt <= mcnt + CNT_W'(1);
                end
                default: ;
            endcase
        end
    end

    a_r7_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_DISARM) |=> (state == ST_IDLE));
    a_r8_no_rearm_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && is_arm) |=> (state != ST_WAIT_RST && state != ST_WAIT_EDGE));
    a_r6_pulse_ends_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_PULSE && state != ST_PULSE) |-> (state == ST_IDLE));
    a_r2_min_one: assert property (@(posedge clk) disable iff (!rst_n)
        (delay_cyc != '0 && width_cyc != '0 && edge_tgt != '0));
endmodule

// File: rtl/tpg_reply_tx.sv
// Reply serialiser: sends "OK\n" or a 36-byte hex status line.
// Fields are captured when the reply starts. A request that arrives
// while a reply is still going out is dropped.
module tpg_reply_tx
    import tpg_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  reply_t           req,
    input  logic [CNT_W-1:0] fld0,
    input  logic [CNT_W-1:0] fld1,
    input  logic [CNT_W-1:0] fld2,
    input  logic [CNT_W-1:0] fld3,
    output logic             tx_valid,
    output logic [7:0]       tx_data,
    input  logic             tx_ready
);
    localparam int OK_LEN   = 3;
    localparam int FLD_CH   = 9;
    localparam int STAT_LEN = 4 * FLD_CH;

    logic        active;
    reply_t      kind;
    logic [5:0]  idx, last;
    logic [31:0] snap [4];
    logic [1:0]  fsel;
    logic [3:0]  pos, nib;

    assign tx_valid = active;
    assign last     = (kind == RP_OK) ? 6'(OK_LEN - 1) : 6'(STAT_LEN - 1);

    // Start a reply, step through its bytes, finish on the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            kind   <= RP_NONE;
            idx    <= '0;
            for (int i = 0; i < 4; i++) snap[i] <= '0;
        end else if (!active) begin
            if (req != RP_NONE) begin
                active  <= 1'b1;
                kind    <= req;
                idx     <= '0;
                snap[0] <= 32'(fld0);
                snap[1] <= 32'(fld1);
                snap[2] <= 32'(fld2);
                snap[3] <= 32'(fld3);
            end
        end else if (tx_ready) begin
            if (idx == last) active <= 1'b0;
            else             idx    <= idx + 6'd1;
        end
    end

    // Byte for the current index.
    always_comb begin
        fsel = 2'(idx / 6'(FLD_CH));
        pos  = 4'(idx % 6'(FLD_CH));
        nib  = 4'(snap[fsel] >> {3'(3'd7 - pos[2:0]), 2'b00});
        if (kind == RP_OK) begin
            case (idx)
                6'd0:    tx_data = 8'h4F;
                6'd1:    tx_data = 8'h4B;
                default: tx_data = CH_LF;
            endcase
        end else if (pos == 4'd8) begin
            tx_data = (idx == 6'(STAT_LEN - 1)) ? CH_LF : CH_SP;
        end else begin
            tx_data = (nib < 4'd10) ? 8'h30 + 8'(nib) : 8'h37 + 8'(nib);
        end
    end

    a_r3_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
endmodule

// File: rtl/trig_pulse_gen.sv
// Top: command parser, input synchronisers, sequencer and reply serialiser.
// sw_en is low only during reset. sw_sel_n is low only during the pulse.
module trig_pulse_gen #(
    parameter int CNT_W         = 32,
    parameter int CLK_PERIOD_NS = 4,
    parameter int EDGE_DEFAULT  = 24
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    input  logic       tx_ready,
    input  logic       line_rst,
    input  logic       line_dat,
    output logic       sw_en,
    output logic       sw_sel_n
);
    logic             cmd_valid, pulse_on;
    logic [7:0]       cmd_op;
    logic [CNT_W-1:0] cmd_val, delay_cyc, width_cyc, edge_tgt, meas_cyc;
    logic [1:0]       rise, toggle;
    tpg_pkg::reply_t  reply_req;

    tpg_cmd_rx #(.VAL_W(CNT_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_val(cmd_val));

    tpg_in_sync #(.N(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .din({line_dat, line_rst}),
        .rise(rise), .toggle(toggle));

    tpg_fire_ctrl #(.CNT_W(CNT_W), .CLK_PERIOD_NS(CLK_PERIOD_NS),
                    .EDGE_DEFAULT(EDGE_DEFAULT)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_val(cmd_val), .rst_rise(rise[0]), .dat_edge(toggle[1]),
        .pulse_on(pulse_on), .reply_req(reply_req), .delay_cyc(delay_cyc),
        .width_cyc(width_cyc), .edge_tgt(edge_tgt), .meas_cyc(meas_cyc));

    tpg_reply_tx #(.CNT_W(CNT_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .req(reply_req), .fld0(delay_cyc),
        .fld1(width_cyc), .fld2(edge_tgt), .fld3(meas_cyc),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready));

    // Enable connects the path once reset is released.
    always_ff @(posedge clk) begin
        if (!rst_n) sw_en <= 1'b0;
        else        sw_en <= 1'b1;
    end

    assign sw_sel_n = ~pulse_on;

    a_r4_en_during_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_sel_n |-> sw_en);
endmodule

// File: tb/trig_pulse_gen_bench.sv
`timescale 1ns/1ps
module trig_pulse_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       tx_valid;
    logic [7:0] tx_data;
    logic       tx_ready = 1'b1;
    logic       line_rst = 1'b0;
    logic       line_dat = 1'b0;
    logic       sw_en, sw_sel_n;

    int  n_chk = 0, n_bad = 0;
    bit  done = 1'b0;
    byte unsigned rxq[$];

    always #2 clk = ~clk;

    trig_pulse_gen u_trig_pulse_gen (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .line_rst(line_rst), .line_dat(line_dat), .sw_en(sw_en), .sw_sel_n(sw_sel_n));

    // Collect reply bytes away from the active edge.
    always @(negedge clk) if (tx_valid && tx_ready) rxq.push_back(tx_data);

    task automatic check(bit ok, string req, string act, string exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %s expected %s", req, act, exp);
        end
    endtask

    task automatic send_byte(logic [7:0] b);
        @(negedge clk); rx_valid = 1'b1; rx_data = b;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic send_line(string s);
        for (int i = 0; i < s.len(); i++) send_byte(s[i]);
        send_byte(8'h0A);
    endtask

    task automatic get_reply(output string r);
        byte unsigned b;
        r = "";
        for (int i = 0; i < 200; i++) begin
            if (rxq.size() > 0 && rxq[rxq.size()-1] == 8'h0A) break;
            @(negedge clk);
        end
        while (rxq.size() > 0) begin
            b = rxq.pop_front();
            if (b == 8'h0A) break;
            r = $sformatf("%s%c", r, b);
        end
    endtask

    task automatic cmd_ok(string c, string req);
        string r;
        send_line(c);
        get_reply(r);
        check(r == "OK", req, r, "OK");
    endtask

    task automatic status_is(string exp, string req);
        string r;
        send_line("S");
        get_reply(r);
        check(r == exp, req, r, exp);
    endtask

    // Count rising edges from a stimulus applied at the preceding negedge.
    task automatic observe(int limit, output int first, output int width, output bit en_drop);
        first = -1; width = 0; en_drop = 1'b0;
        for (int n = 1; n <= limit; n++) begin
            @(posedge clk); @(negedge clk);
            if (!sw_sel_n) begin
                if (first < 0) first = n;
                width++;
            end
            if (!sw_en) en_drop = 1'b1;
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(sw_en == 1'b0, "R1", $sformatf("en=%0b", sw_en), "en=0");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(sw_en == 1'b1, "R1", $sformatf("en=%0b", sw_en), "en=1");
        check(sw_sel_n == 1'b1, "R1", $sformatf("sel_n=%0b", sw_sel_n), "sel_n=1");
        status_is("00000001 00000001 00000018 00000000", "R1 R10 defaults");
    endtask

    task automatic t_config();
        int sz;
        cmd_ok("D10", "R3 D");
        cmd_ok("E3", "R3 E");
        send_byte(8'h57); send_byte(8'h37); send_byte(8'h0D); send_byte(8'h0A);
        begin string r; get_reply(r); check(r == "OK", "R3 CR ignored", r, "OK"); end
        status_is("00000003 00000002 00000003 00000000", "R2 rounding");
        cmd_ok("D0", "R2");
        status_is("00000001 00000002 00000003 00000000", "R2 minimum");
        cmd_ok("D10", "R2");
        send_line("Q");
        repeat (20) @(negedge clk);
        sz = rxq.size();
        check(sz == 0, "R3 unknown", $sformatf("%0d bytes", sz), "0 bytes");
    endtask

    task automatic t_reset_mode();
        int f, w; bit d;
        cmd_ok("R", "R4 arm");
        line_rst = 1'b1;
        observe(30, f, w, d);
        check(f == 6, "R4 start", $sformatf("%0d", f), "6");
        check(w == 2, "R4 width", $sformatf("%0d", w), "2");
        check(!d, "R4 enable", "en dropped", "en held");
    endtask

    task automatic t_one_shot();
        int f, w; bit d;
        line_rst = 1'b0;
        repeat (4) @(negedge clk);
        line_rst = 1'b1;
        observe(30, f, w, d);
        check(f == -1, "R6 no refire", $sformatf("%0d", f), "-1");
    endtask

    task automatic t_edge_mode();
        int f, w; bit d;
        cmd_ok("D0", "R5"); cmd_ok("W8", "R5"); cmd_ok("E3", "R5");
        cmd_ok("B", "R5 arm");
        line_dat = ~line_dat; observe(4, f, w, d);
        check(f == -1, "R5 edge1", $sformatf("%0d", f), "-1");
        line_dat = ~line_dat; observe(4, f, w, d);
        check(f == -1, "R5 edge2", $sformatf("%0d", f), "-1");
        line_dat = ~line_dat; observe(20, f, w, d);
        check(f == 4, "R5 start", $sformatf("%0d", f), "4");
        check(w == 2, "R5 width", $sformatf("%0d", w), "2");
    endtask

    task automatic t_busy_arm();
        int f, w, sz; bit d;
        cmd_ok("D40", "R8"); cmd_ok("W20", "R8");
        line_rst = 1'b0;
        repeat (4) @(negedge clk);
        cmd_ok("R", "R8 arm");
        line_rst = 1'b1;
        fork
            observe(40, f, w, d);
            begin repeat (3) @(negedge clk); send_line("B"); end
        join
        check(f == 13, "R8 start", $sformatf("%0d", f), "13");
        check(w == 5, "R8 width", $sformatf("%0d", w), "5");
        sz = rxq.size();
        check(sz == 0, "R8 no reply", $sformatf("%0d bytes", sz), "0 bytes");
        for (int i = 0; i < 3; i++) begin line_dat = ~line_dat; repeat (4) @(negedge clk); end
        observe(10, f, w, d);
        check(f == -1, "R8 not armed", $sformatf("%0d", f), "-1");
    endtask

    task automatic t_abort();
        int f, w; bit d;
        string r;
        line_rst = 1'b0;
        repeat (4) @(negedge clk);
        cmd_ok("R", "R7 arm");
        line_rst = 1'b1;
        fork
            observe(40, f, w, d);
            begin repeat (4) @(negedge clk); send_line("X"); end
        join
        check(f == -1, "R7 aborted", $sformatf("%0d", f), "-1");
        get_reply(r);
        check(r == "OK", "R7 ack", r, "OK");
    endtask

    task automatic t_measure();
        cmd_ok("T", "R9 arm");
        line_dat = ~line_dat;
        repeat (10) @(negedge clk);
        line_dat = ~line_dat;
        repeat (6) @(negedge clk);
        status_is("0000000A 00000005 00000003 0000000A", "R9 R10 measure");
    endtask

    task automatic t_overlap();
        int f, w; bit d;
        cmd_ok("E2", "R5"); cmd_ok("D0", "R2"); cmd_ok("W4", "R2");
        cmd_ok("B", "R5 arm"); cmd_ok("T", "R9 arm");
        line_dat = ~line_dat;
        repeat (7) @(negedge clk);
        line_dat = ~line_dat;
        observe(20, f, w, d);
        check(f == 4, "R5 shared edge", $sformatf("%0d", f), "4");
        check(w == 1, "R2 width 1", $sformatf("%0d", w), "1");
        status_is("00000001 00000001 00000002 00000007", "R9 shared edge");
    endtask

    initial begin
        t_reset();
        t_config();
        t_reset_mode();
        t_one_shot();
        t_edge_mode();
        t_busy_arm();
        t_abort();
        t_measure();
        t_overlap();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule